// File: doc/BRIEF.md
# Accumulator ALU with Status Flags

This block is the 8-bit arithmetic and logic unit of an accumulator-based CPU. Each cycle in which `op_valid_i` is high, it takes the current accumulator value, one operand byte (an immediate, a scratchpad register or a memory byte, chosen outside the block), the current carry flag and a 4-bit operation code. It returns the result together with overflow, zero, carry and sign flags. All of these are registered, so they appear one cycle later. Two write-enable strobes tell the surrounding datapath whether to store the result in the accumulator and whether to store the flags in the status register.

The operations are binary add, add of the carry flag (link), increment, decrement of the operand (done by adding 0xFF), packed-BCD add, compare, AND, OR, XOR, complement, and zero-filling shifts by one or four places in either direction. The sign flag is 1 when the result is non-negative. Logic and shift operations force overflow and carry to 0. Compare subtracts the accumulator from the operand and changes only the flags. The block holds no register file and does not access memory.

Top module: `acc_alu`

## Requirements
- R1: A request sampled with `op_valid_i` high produces `res_valid_o`=1 with its result, flags and write enables on the next cycle. When `op_valid_i` is low, `res_valid_o` is 0 on the next cycle and the result, flags and enables keep their values. While reset is asserted, all outputs are 0.
- R2: When `flag_we_o` is 1, `zero_o` is 1 exactly when the result is 0. Except for right shifts, `sign_o` is 1 exactly when result bit 7 is 0.
- R3: Code 0 (add) returns acc+operand. Code 1 (link) returns acc+`carry_i`. Code 2 (increment) returns acc+1. For each, carry is the carry out of bit 7, and overflow is the carry into bit 7 XOR the carry out of bit 7.
- R4: Code 3 (decrement) returns operand+0xFF. Carry and overflow follow the R3 rule for that sum.
- R5: Code 9 (compare) returns operand + ~acc + 1. Carry and overflow follow the R3 rule for that sum, and `acc_we_o` is 0.
- R6: Code 4 (decimal add) returns the packed-BCD sum of two packed-BCD bytes, modulo 100. Carry is 1 when the decimal sum reaches 100. Overflow is the R3 rule applied to the plain binary sum acc+operand.
- R7: Codes 5 (AND), 6 (OR), 7 (XOR) and 8 (complement of acc) give overflow 0 and carry 0.
- R8: Codes 10 (right by 1) and 12 (right by 4) shift acc with zero fill, give overflow 0 and carry 0, and set the sign flag to 1.
- R9: Codes 11 (left by 1) and 13 (left by 4) shift acc with zero fill and give overflow 0 and carry 0.
- R10: Codes 14 and 15 are reserved. They return acc unchanged with `acc_we_o`=0 and `flag_we_o`=0.
- R11: For codes 0 to 13, `flag_we_o` is 1. For the same codes `acc_we_o` is 1, except for compare.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid_i | input | 1 | Request strobe |
| op_code_i | input | 4 | Operation code |
| acc_i | input | 8 | Accumulator value |
| opnd_i | input | 8 | Operand byte |
| carry_i | input | 1 | Current carry flag |
| res_valid_o | output | 1 | Result valid |
| result_o | output | 8 | Result byte |
| acc_we_o | output | 1 | Write result to accumulator |
| flag_we_o | output | 1 | Write flags to status register |
| ovf_o | output | 1 | Overflow flag |
| zero_o | output | 1 | Zero flag |
| carry_o | output | 1 | Carry flag |
| sign_o | output | 1 | Sign flag (1 = non-negative) |

## Verification
The block holds no state beyond its output registers, so any wrong operand routing, carry chain or flag rule shows up at the ports one cycle after the faulty request. Each vector is paired with an expected result and flag set computed from plain integer and decimal arithmetic. Carry and overflow corners are covered by 0x7F+1, 0xFF+1, borrow in both directions for compare, and BCD carries out of each digit. A register that fails to hold shows up as a changed result during an idle cycle after a valid one.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;
  localparam int DW = 8;
  localparam int NIB = 4;

  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_LINK = 4'd1,
    OP_INC  = 4'd2,
    OP_DEC  = 4'd3,
    OP_DADD = 4'd4,
    OP_AND  = 4'd5,
    OP_OR   = 4'd6,
    OP_XOR  = 4'd7,
    OP_COM  = 4'd8,
    OP_CMP  = 4'd9,
    OP_SHR1 = 4'd10,
    OP_SHL1 = 4'd11,
    OP_SHR4 = 4'd12,
    OP_SHL4 = 4'd13,
    OP_RSV0 = 4'd14,
    OP_RSV1 = 4'd15
  } alu_op_e;

  typedef struct packed {
    logic ovf;
    logic zero;
    logic carry;
    logic sign;
  } alu_flags_t;
endpackage

// File: rtl/alu_rst_sync.sv
module alu_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/alu_adder.sv
module alu_adder #(
  parameter int W = 8
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic         ci,
  output logic [W-1:0] sum,
  output logic         c_into_msb,
  output logic         c_out
);
  logic [W-1:0] low_sum;
  logic [W:0]   full_sum;

  assign low_sum    = {1'b0, x[W-2:0]} + {1'b0, y[W-2:0]} + {{(W-1){1'b0}}, ci};
  assign full_sum   = {1'b0, x} + {1'b0, y} + {{W{1'b0}}, ci};
  assign c_into_msb = low_sum[W-1];
  assign c_out      = full_sum[W];
  assign sum        = full_sum[W-1:0];
endmodule

// File: rtl/alu_bcd.sv
module alu_bcd #(
  parameter int W   = 8,
  parameter int NIB = 4
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  output logic [W-1:0] sum,
  output logic         c_out
);
  localparam int DIGITS = W / NIB;

  logic [DIGITS:0] dig_c;
  assign dig_c[0] = 1'b0;

  for (genvar g = 0; g < DIGITS; g++) begin : g_digit
    logic [NIB:0] raw;
    assign raw = {1'b0, x[g*NIB +: NIB]} + {1'b0, y[g*NIB +: NIB]}
               + (NIB+1)'(6) + {{NIB{1'b0}}, dig_c[g]};
    assign dig_c[g+1] = raw[NIB];
    assign sum[g*NIB +: NIB] = raw[NIB] ? raw[NIB-1:0] : (raw[NIB-1:0] - NIB'(6));
  end

  assign c_out = dig_c[DIGITS];
endmodule

// File: rtl/alu_logic.sv
module alu_logic
  import acc_alu_pkg::*;
#(
  parameter int W  = 8,
  parameter int SH = 4
) (
  input  alu_op_e      op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] res
);
  always_comb begin
    case (op)
      OP_AND:  res = a & b;
      OP_OR:   res = a | b;
      OP_XOR:  res = a ^ b;
      OP_COM:  res = ~a;
      OP_SHR1: res = a >> 1;
      OP_SHL1: res = a << 1;
      OP_SHR4: res = a >> SH;
      OP_SHL4: res = a << SH;
      default: res = a;
    endcase
  end
endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import acc_alu_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          op_valid_i,
  input  logic [3:0]    op_code_i,
  input  logic [DW-1:0] acc_i,
  input  logic [DW-1:0] opnd_i,
  input  logic          carry_i,
  output logic          res_valid_o,
  output logic [DW-1:0] result_o,
  output logic          acc_we_o,
  output logic          flag_we_o,
  output logic          ovf_o,
  output logic          zero_o,
  output logic          carry_o,
  output logic          sign_o
);
  alu_op_e       op;
  logic          rst_sync_n;
  logic [DW-1:0] add_x, add_y, add_sum, bcd_sum, lgc_res, res_d;
  logic          add_ci, add_c7, add_co, bcd_co;
  logic          is_arith, is_dec, is_shr, is_defined;
  alu_flags_t    flags_d, flags_q;
  logic          acc_we_d, flag_we_d;
  logic          vld_q, acc_we_q, flag_we_q;
  logic [DW-1:0] res_q;

  assign op = alu_op_e'(op_code_i);

  alu_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  // operand steering into the shared binary adder
  always_comb begin
    add_x  = acc_i;
    add_y  = opnd_i;
    add_ci = 1'b0;
    case (op)
      OP_LINK: begin add_y = '0; add_ci = carry_i; end
      OP_INC:  begin add_y = '0; add_ci = 1'b1; end
      OP_DEC:  begin add_x = opnd_i; add_y = '1; end
      OP_CMP:  begin add_x = opnd_i; add_y = ~acc_i; add_ci = 1'b1; end
      default: ;
    endcase
  end

  alu_adder #(.W(DW)) u_add (
    .x(add_x), .y(add_y), .ci(add_ci),
    .sum(add_sum), .c_into_msb(add_c7), .c_out(add_co)
  );

  alu_bcd #(.W(DW), .NIB(NIB)) u_bcd (
    .x(acc_i), .y(opnd_i), .sum(bcd_sum), .c_out(bcd_co)
  );

  alu_logic #(.W(DW), .SH(NIB)) u_lgc (
    .op(op), .a(acc_i), .b(opnd_i), .res(lgc_res)
  );

  always_comb begin
    is_arith   = (op == OP_ADD) || (op == OP_LINK) || (op == OP_INC)
              || (op == OP_DEC) || (op == OP_CMP);
    is_dec     = (op == OP_DADD);
    is_shr     = (op == OP_SHR1) || (op == OP_SHR4);
    is_defined = (op != OP_RSV0) && (op != OP_RSV1);

    if (is_arith)    res_d = add_sum;
    else if (is_dec) res_d = bcd_sum;
    else             res_d = lgc_res;

    flags_d.carry = is_arith ? add_co : (is_dec ? bcd_co : 1'b0);
    flags_d.ovf   = (is_arith || is_dec) ? (add_c7 ^ add_co) : 1'b0;
    flags_d.zero  = (res_d == '0);
    flags_d.sign  = is_shr ? 1'b1 : ~res_d[DW-1];

    flag_we_d = is_defined;
    acc_we_d  = is_defined && (op != OP_CMP);
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      vld_q     <= 1'b0;
      res_q     <= '0;
      flags_q   <= '0;
      acc_we_q  <= 1'b0;
      flag_we_q <= 1'b0;
    end else begin
      vld_q <= op_valid_i;
      if (op_valid_i) begin
        res_q     <= res_d;
        flags_q   <= flags_d;
        acc_we_q  <= acc_we_d;
        flag_we_q <= flag_we_d;
      end
    end
  end

  assign res_valid_o = vld_q;
  assign result_o    = res_q;
  assign acc_we_o    = acc_we_q;
  assign flag_we_o   = flag_we_q;
  assign ovf_o       = flags_q.ovf;
  assign zero_o      = flags_q.zero;
  assign carry_o     = flags_q.carry;
  assign sign_o      = flags_q.sign;
endmodule

// File: rtl/acc_alu_chk.sv
module acc_alu_chk
  import acc_alu_pkg::*;
(
  input logic          clk,
  input logic          rst_sync_n,
  input logic          op_valid_i,
  input logic [3:0]    op_code_i,
  input logic [DW-1:0] acc_i,
  input logic          res_valid_o,
  input logic [DW-1:0] result_o,
  input logic          acc_we_o,
  input logic          flag_we_o,
  input logic          ovf_o,
  input logic          zero_o,
  input logic          carry_o,
  input logic          sign_o
);
  // R1
  valid_lat_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    op_valid_i |=> res_valid_o);

  // R1
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !op_valid_i |=> (!res_valid_o && $stable(result_o) && $stable(carry_o)));

  // R2
  zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (res_valid_o && flag_we_o) |-> (zero_o == (result_o == '0)));

  // R5
  cmp_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (op_valid_i && op_code_i == OP_CMP) |=> (!acc_we_o && flag_we_o));

  // R7
  logic_clear_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (op_valid_i && (op_code_i == OP_AND || op_code_i == OP_OR ||
                    op_code_i == OP_XOR || op_code_i == OP_COM))
    |=> (!ovf_o && !carry_o));

  // R8
  shr_sign_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (op_valid_i && (op_code_i == OP_SHR1 || op_code_i == OP_SHR4))
    |=> (sign_o && !ovf_o && !carry_o));

  // R9
  shl_one_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (op_valid_i && op_code_i == OP_SHL1)
    |=> (result_o == {$past(acc_i[DW-2:0]), 1'b0}));

  // R10
  rsv_pass_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (op_valid_i && op_code_i >= OP_RSV0)
    |=> (!acc_we_o && !flag_we_o && result_o == $past(acc_i)));
endmodule

bind acc_alu acc_alu_chk u_chk (
  .clk(clk), .rst_sync_n(rst_sync_n), .op_valid_i(op_valid_i),
  .op_code_i(op_code_i), .acc_i(acc_i), .res_valid_o(res_valid_o),
  .result_o(result_o), .acc_we_o(acc_we_o), .flag_we_o(flag_we_o),
  .ovf_o(ovf_o), .zero_o(zero_o), .carry_o(carry_o), .sign_o(sign_o)
);

// File: tb/tb_acc_alu.sv
module tb_acc_alu;
  localparam int CLK_PERIOD = 10;
  localparam int VN = 24;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       op_valid_i;
  logic [3:0] op_code_i;
  logic [7:0] acc_i, opnd_i;
  logic       carry_i;
  logic       res_valid_o, acc_we_o, flag_we_o, ovf_o, zero_o, carry_o, sign_o;
  logic [7:0] result_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  acc_alu dut (
    .clk(clk), .rst_n(rst_n), .op_valid_i(op_valid_i), .op_code_i(op_code_i),
    .acc_i(acc_i), .opnd_i(opnd_i), .carry_i(carry_i),
    .res_valid_o(res_valid_o), .result_o(result_o), .acc_we_o(acc_we_o),
    .flag_we_o(flag_we_o), .ovf_o(ovf_o), .zero_o(zero_o),
    .carry_o(carry_o), .sign_o(sign_o)
  );

  // {op, acc, operand, carry_in, expected result}
  localparam logic [28:0] VEC [VN] = '{
    {4'd0,  8'h12, 8'h34, 1'b0, 8'h46},
    {4'd0,  8'h7F, 8'h01, 1'b0, 8'h80},
    {4'd0,  8'hFF, 8'h01, 1'b0, 8'h00},
    {4'd1,  8'h41, 8'h99, 1'b1, 8'h42},
    {4'd1,  8'hFF, 8'h00, 1'b1, 8'h00},
    {4'd1,  8'h33, 8'h00, 1'b0, 8'h33},
    {4'd2,  8'h7F, 8'h00, 1'b0, 8'h80},
    {4'd3,  8'h00, 8'h00, 1'b0, 8'hFF},
    {4'd3,  8'h00, 8'h01, 1'b0, 8'h00},
    {4'd4,  8'h15, 8'h27, 1'b0, 8'h42},
    {4'd4,  8'h99, 8'h01, 1'b0, 8'h00},
    {4'd4,  8'h58, 8'h46, 1'b0, 8'h04},
    {4'd5,  8'hF0, 8'h3C, 1'b0, 8'h30},
    {4'd6,  8'h0F, 8'h80, 1'b0, 8'h8F},
    {4'd7,  8'hAA, 8'hAA, 1'b0, 8'h00},
    {4'd8,  8'h55, 8'h00, 1'b0, 8'hAA},
    {4'd9,  8'h10, 8'h30, 1'b0, 8'h20},
    {4'd9,  8'h30, 8'h10, 1'b0, 8'hE0},
    {4'd10, 8'h81, 8'h00, 1'b0, 8'h40},
    {4'd11, 8'h81, 8'h00, 1'b0, 8'h02},
    {4'd12, 8'hAB, 8'h00, 1'b0, 8'h0A},
    {4'd13, 8'hAB, 8'h00, 1'b0, 8'hB0},
    {4'd11, 8'h80, 8'h00, 1'b0, 8'h00},
    {4'd14, 8'h5A, 8'h11, 1'b0, 8'h5A}
  };

  function automatic string req_of(int op);
    case (op)
      0, 1, 2:   return "R3";
      3:         return "R4";
      4:         return "R6";
      5, 6, 7, 8: return "R7";
      9:         return "R5";
      10, 12:    return "R8";
      11, 13:    return "R9";
      default:   return "R10";
    endcase
  endfunction

  // returns {ovf, zero, carry, sign, acc_we, flag_we}
  function automatic logic [5:0] model(int op, int a, int b, int ci);
    int r, c7, c8, ov, d;
    r = a; c7 = 0; c8 = 0; ov = 0;
    case (op)
      0: begin r = a + b;           c7 = ((a & 127) + (b & 127)) >> 7; end
      1: begin r = a + ci;          c7 = ((a & 127) + ci) >> 7; end
      2: begin r = a + 1;           c7 = ((a & 127) + 1) >> 7; end
      3: begin r = b + 255;         c7 = ((b & 127) + 127) >> 7; end
      9: begin r = b + (255 - a) + 1; c7 = ((b & 127) + ((255 - a) & 127) + 1) >> 7; end
      default: ;
    endcase
    if (op <= 3 || op == 9) begin
      c8 = (r >> 8) & 1; r = r & 255; ov = c7 ^ c8;
    end
    if (op == 4) begin
      d = (a >> 4) * 10 + (a & 15) + (b >> 4) * 10 + (b & 15);
      c8 = (d >= 100) ? 1 : 0;
      d = d % 100;
      r = (d / 10) * 16 + (d % 10);
      ov = (((a & 127) + (b & 127)) >> 7) ^ ((a + b) >> 8);
    end
    case (op)
      5: r = a & b;
      6: r = a | b;
      7: r = a ^ b;
      8: r = 255 - a;
      10: r = a >> 1;
      11: r = (a << 1) & 255;
      12: r = a >> 4;
      13: r = (a << 4) & 255;
      default: ;
    endcase
    return {ov[0], (r == 0), c8[0],
            ((op == 10 || op == 12) ? 1'b1 : ~r[7]),
            (op <= 13 && op != 9), (op <= 13)};
  endfunction

  task automatic check(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic apply(int op, int a, int b, int ci);
    @(negedge clk);
    op_valid_i = 1'b1; op_code_i = 4'(op); acc_i = 8'(a); opnd_i = 8'(b); carry_i = ci[0];
    @(negedge clk);
    op_valid_i = 1'b0;
  endtask

  initial begin
    logic [5:0] m;
    logic [7:0] held;
    rst_n = 1'b0; op_valid_i = 1'b0; op_code_i = '0;
    acc_i = '0; opnd_i = '0; carry_i = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", "reset outputs",
          {res_valid_o, result_o, acc_we_o, flag_we_o, ovf_o, zero_o, carry_o, sign_o}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1", "idle after reset valid", res_valid_o, 0);

    for (int i = 0; i < VN; i++) begin
      apply(int'(VEC[i][28:25]), int'(VEC[i][24:17]), int'(VEC[i][16:9]), int'(VEC[i][8]));
      m = model(int'(VEC[i][28:25]), int'(VEC[i][24:17]), int'(VEC[i][16:9]), int'(VEC[i][8]));
      check("R1", "valid", res_valid_o, 1);
      check(req_of(int'(VEC[i][28:25])), "result", result_o, int'(VEC[i][7:0]));
      check(req_of(int'(VEC[i][28:25])), "ovf/carry", {ovf_o, carry_o}, {m[5], m[3]});
      check("R2", "zero/sign", {zero_o, sign_o}, {m[4], m[2]});
      check("R11", "write enables", {acc_we_o, flag_we_o}, m[1:0]);
    end

    // R1 hold: idle cycle keeps previous outputs
    apply(0, 8'h7F, 8'h01, 0);
    held = result_o;
    @(negedge clk);
    check("R1", "valid drops when idle", res_valid_o, 0);
    check("R1", "result held when idle", result_o, held);
    check("R1", "flags held when idle", {ovf_o, sign_o}, 2'b10);

    // R10 second reserved code leaves no write strobes
    apply(15, 8'hC3, 8'h00, 1);
    check("R10", "reserved result", result_o, 8'hC3);
    check("R10", "reserved enables", {acc_we_o, flag_we_o}, 0);

    // R5 equal compare: zero, no borrow, no write
    apply(9, 8'h44, 8'h44, 0);
    check("R5", "equal compare flags", {zero_o, carry_o, ovf_o, acc_we_o}, 4'b1100);

    // R1 back-to-back requests
    @(negedge clk);
    op_valid_i = 1'b1; op_code_i = 4'd2; acc_i = 8'h01; opnd_i = 8'h00;
    @(negedge clk);
    check("R3", "first of pair", result_o, 8'h02);
    op_code_i = 4'd2; acc_i = 8'hFF;
    @(negedge clk);
    op_valid_i = 1'b0;
    check("R3", "second of pair", {result_o, carry_o, res_valid_o}, {8'h00, 1'b1, 1'b1});

    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL R1 watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule